// File: doc/BRIEF.md
# Receive Descriptor Path Controller

This block is the sequencing state machine that sits behind a network receiver and decides, packet by packet, whether an accepted incoming frame can be stored in memory. For each accepted frame it issues, one at a time, the memory-area accesses needed to keep it: a transfer into the receive buffer area, a descriptor write-back into the receive descriptor area, and, when the current buffer is running out, a fetch of a fresh resource entry from the resource area. Data movement, MAC logic and address arithmetic are done elsewhere. This block only chooses which area is requested and in what order.

The path taken depends on whether the descriptor used by the previous reception was marked as the last one in the list. If it was not, the frame is stored straight away. If it was, the controller first reads the link field of that descriptor again, to see whether software has since appended a free descriptor. When the end-of-list bit in that field has been cleared, the frame is stored as usual. When the bit is still set, the frame is dropped with a single-cycle reject pulse and nothing is written to memory.

Each request stays asserted until the shared done handshake arrives. A new frame is taken only when the controller is idle.

Top module: `rxdesc_path_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every area request and the reject pulse are low.
- R2: When a frame request is taken in idle and `eol_prev` is 0, the buffer-area request (`req_rba`) rises in the next cycle.
- R3: When the buffer access completes, the next cycle requests a descriptor-area write (`req_rda`=1 with `rda_we`=1).
- R4: When the descriptor write completes, a resource-area read (`req_rra`) follows in the next cycle if `rbwc` < `eobc` as sampled in the cycle the buffer access completed. Otherwise the controller returns to idle.
- R5: When a frame request is taken in idle and `eol_prev` is 1, the next cycle requests a descriptor-area read (`req_rda`=1, `rda_we`=0) that rereads the link field.
- R6: If bit 0 of `link_data` is 0 when the reread completes, the buffer-area request follows in the next cycle, whatever the other link bits hold, and the frame then completes as in R3 and R4.
- R7: If bit 0 of `link_data` is 1 when the reread completes, `pkt_reject` is high for exactly the next cycle with no area request, and the controller is then idle.
- R8: Each area request is held steady until a cycle with `mem_done` high, and at most one of `req_rba`, `req_rda`, `req_rra`, `pkt_reject` is high in any cycle.
- R9: `pkt_req` has no effect unless the controller is idle. A request raised during a frame's sequence produces no further accesses after that sequence ends.
- R10: When `rbwc` equals `eobc` the buffer is not depleted and no resource read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pkt_req | input | 1 | An incoming frame has been accepted and needs storing |
| eol_prev | input | 1 | End-of-list flag kept from the previous reception |
| link_data | input | LINK_W | Link field returned by the descriptor reread, valid with `mem_done` |
| rbwc | input | CNT_W | Remaining receive-buffer word count |
| eobc | input | CNT_W | End-of-buffer word-count threshold |
| mem_done | input | 1 | Completion handshake for the current area access |
| req_rba | output | 1 | Request a transfer to the receive buffer area |
| req_rda | output | 1 | Request an access to the receive descriptor area |
| rda_we | output | 1 | Direction of the descriptor access: 1 write-back, 0 link reread |
| req_rra | output | 1 | Request a resource entry read from the resource area |
| pkt_reject | output | 1 | One-cycle pulse: the frame was dropped |

## Verification
Every output is decoded directly from the state register. The first request of a frame is therefore visible one cycle after the clock edge that sees `pkt_req`, and each following request one cycle after the edge that sees `mem_done`. The reject pulse occupies the cycle after the reread completes, and idle follows one cycle later. The bench drives inputs and samples outputs on the falling edge. It checks the expected area code right after each of those rising edges, checks that the code stays the same through every wait cycle before `mem_done` is raised, and checks idle one and two cycles after the last completion.

// File: rtl/rxdp_pkg.sv
package rxdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REREAD = 3'd1,
        ST_BUF    = 3'd2,
        ST_DESC   = 3'd3,
        ST_RSRC   = 3'd4,
        ST_REJECT = 3'd5
    } rx_state_e;

    typedef struct packed {
        logic rba;
        logic rda;
        logic rda_wr;
        logic rra;
        logic reject;
    } area_req_t;

    function automatic area_req_t decode_state(input rx_state_e st);
        area_req_t r;
        r = '0;
        case (st)
            ST_REREAD: r.rda = 1'b1;
            ST_BUF:    r.rba = 1'b1;
            ST_DESC: begin
                r.rda    = 1'b1;
                r.rda_wr = 1'b1;
            end
            ST_RSRC:   r.rra = 1'b1;
            ST_REJECT: r.reject = 1'b1;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxdp_lowbuf.sv
module rxdp_lowbuf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [CNT_W-1:0] rbwc,
    input  logic [CNT_W-1:0] eobc,
    output logic             low_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= 1'b0;
        end else if (capture) begin
            low_q <= (rbwc < eobc);
        end
    end
endmodule

// File: rtl/rxdp_fsm.sv
module rxdp_fsm
    import rxdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pkt_req,
    input  logic      eol_prev,
    input  logic      mem_done,
    input  logic      link_eol,
    input  logic      low_q,
    output rx_state_e state
);
    rx_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (pkt_req)  nxt = eol_prev ? ST_REREAD : ST_BUF;
            ST_REREAD: if (mem_done) nxt = link_eol ? ST_REJECT : ST_BUF;
            ST_BUF:    if (mem_done) nxt = ST_DESC;
            ST_DESC:   if (mem_done) nxt = low_q ? ST_RSRC : ST_IDLE;
            ST_RSRC:   if (mem_done) nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/rxdp_outdec.sv
module rxdp_outdec
    import rxdp_pkg::*;
(
    input  rx_state_e state,
    output logic      req_rba,
    output logic      req_rda,
    output logic      rda_we,
    output logic      req_rra,
    output logic      pkt_reject
);
    area_req_t r;

    always_comb begin
        r          = decode_state(state);
        req_rba    = r.rba;
        req_rda    = r.rda;
        rda_we     = r.rda_wr;
        req_rra    = r.rra;
        pkt_reject = r.reject;
    end
endmodule

// File: rtl/rxdesc_path_ctrl.sv
module rxdesc_path_ctrl
    import rxdp_pkg::*;
#(
    parameter int LINK_W  = 32,
    parameter int CNT_W   = 16,
    parameter int EOL_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_req,
    input  logic              eol_prev,
    input  logic [LINK_W-1:0] link_data,
    input  logic [CNT_W-1:0]  rbwc,
    input  logic [CNT_W-1:0]  eobc,
    input  logic              mem_done,
    output logic              req_rba,
    output logic              req_rda,
    output logic              rda_we,
    output logic              req_rra,
    output logic              pkt_reject
);
    rx_state_e state;
    logic      low_q;
    logic      link_eol;
    logic      buf_done;
    logic      link_unused;

    assign link_eol    = link_data[EOL_BIT];
    assign link_unused = ^link_data;
    assign buf_done    = (state == ST_BUF) && mem_done;

    rxdp_lowbuf #(.CNT_W(CNT_W)) u_lowbuf (
        .clk     (clk),
        .rst     (rst),
        .capture (buf_done),
        .rbwc    (rbwc),
        .eobc    (eobc),
        .low_q   (low_q)
    );

    rxdp_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pkt_req  (pkt_req),
        .eol_prev (eol_prev),
        .mem_done (mem_done),
        .link_eol (link_eol),
        .low_q    (low_q),
        .state    (state)
    );

    rxdp_outdec u_outdec (
        .state      (state),
        .req_rba    (req_rba),
        .req_rda    (req_rda),
        .rda_we     (rda_we),
        .req_rra    (req_rra),
        .pkt_reject (pkt_reject)
    );
endmodule

// File: rtl/rxdp_chk.sv
module rxdp_chk (
    input logic clk,
    input logic rst,
    input logic mem_done,
    input logic req_rba,
    input logic req_rda,
    input logic rda_we,
    input logic req_rra,
    input logic pkt_reject
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(req_rba || req_rda || req_rra || pkt_reject));

    p_one_area_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_rba, req_rda, req_rra, pkt_reject}));

    p_hold_rba_r8: assert property (@(posedge clk) disable iff (rst)
        (req_rba && !mem_done) |=> req_rba);

    p_hold_rda_r8: assert property (@(posedge clk) disable iff (rst)
        (req_rda && !mem_done) |=> (req_rda && $stable(rda_we)));

    p_hold_rra_r8: assert property (@(posedge clk) disable iff (rst)
        (req_rra && !mem_done) |=> req_rra);

    p_desc_after_buf_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(req_rda && rda_we) |-> $past(req_rba && mem_done));

    p_rsrc_after_desc_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(req_rra) |-> $past(req_rda && rda_we && mem_done));

    p_reject_after_reread_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_reject |-> $past(req_rda && !rda_we && mem_done));

    p_reject_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_reject |=> !(pkt_reject || req_rba || req_rda || req_rra));
endmodule

bind rxdesc_path_ctrl rxdp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_done   (mem_done),
    .req_rba    (req_rba),
    .req_rda    (req_rda),
    .rda_we     (rda_we),
    .req_rra    (req_rra),
    .pkt_reject (pkt_reject)
);

// File: tb/tb_rxdesc_path_ctrl.sv
module tb_rxdesc_path_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LINK_W = 32;
    localparam int CNT_W  = 16;
    localparam int WATCHDOG = 20000;

    localparam logic [4:0] O_IDLE = 5'b00000;
    localparam logic [4:0] O_BUF  = 5'b00001;
    localparam logic [4:0] O_DWR  = 5'b00110;
    localparam logic [4:0] O_RRD  = 5'b00100;
    localparam logic [4:0] O_RSRC = 5'b01000;
    localparam logic [4:0] O_REJ  = 5'b10000;

    typedef struct packed {
        logic             eol;
        logic             lbit;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mark;
        logic [3:0]       dly;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{eol: 1'b0, lbit: 1'b0, cnt: 16'd100, mark: 16'd10, dly: 4'd0},
        '{eol: 1'b0, lbit: 1'b1, cnt: 16'd5,   mark: 16'd10, dly: 4'd2},
        '{eol: 1'b1, lbit: 1'b0, cnt: 16'd50,  mark: 16'd10, dly: 4'd1},
        '{eol: 1'b1, lbit: 1'b1, cnt: 16'd50,  mark: 16'd10, dly: 4'd0},
        '{eol: 1'b1, lbit: 1'b0, cnt: 16'd3,   mark: 16'd10, dly: 4'd3},
        '{eol: 1'b0, lbit: 1'b0, cnt: 16'd10,  mark: 16'd10, dly: 4'd1},
        '{eol: 1'b1, lbit: 1'b1, cnt: 16'd2,   mark: 16'd10, dly: 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pkt_req = 1'b0;
    logic              eol_prev = 1'b0;
    logic [LINK_W-1:0] link_data = '0;
    logic [CNT_W-1:0]  rbwc = '0;
    logic [CNT_W-1:0]  eobc = '0;
    logic              mem_done = 1'b0;
    logic              req_rba, req_rda, rda_we, req_rra, pkt_reject;
    logic [4:0]        obs;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdesc_path_ctrl #(.LINK_W(LINK_W), .CNT_W(CNT_W), .EOL_BIT(0)) dut (
        .clk(clk), .rst(rst), .pkt_req(pkt_req), .eol_prev(eol_prev),
        .link_data(link_data), .rbwc(rbwc), .eobc(eobc), .mem_done(mem_done),
        .req_rba(req_rba), .req_rda(req_rda), .rda_we(rda_we),
        .req_rra(req_rra), .pkt_reject(pkt_reject)
    );

    assign obs = {pkt_reject, req_rra, req_rda, rda_we, req_rba};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [4:0] exp);
        checks = checks + 1;
        if (obs !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%05b expected=%05b", req, obs, exp);
        end
    endtask

    // Current negedge shows exp; hold dly cycles (poking pkt_req), then complete.
    task automatic access(input string req, input logic [4:0] exp, input int dly);
        chk(req, exp);
        for (int i = 0; i < dly; i++) begin
            pkt_req = 1'b1;
            @(negedge clk);
            chk("R8 hold", exp);
        end
        pkt_req  = 1'b0;
        mem_done = 1'b1;
        @(negedge clk);
        mem_done = 1'b0;
    endtask

    task automatic start_pkt();
        pkt_req = 1'b1;
        @(negedge clk);
        pkt_req = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic rej;
        logic low;
        rej = v.eol && v.lbit;
        low = v.cnt < v.mark;
        eol_prev  = v.eol;
        rbwc      = v.cnt;
        eobc      = v.mark;
        link_data = {31'h2AAA_5555, v.lbit};
        start_pkt();
        if (v.eol) begin
            access("R5 reread", O_RRD, int'(v.dly));
            if (rej) begin
                chk("R7 reject pulse", O_REJ);
                @(negedge clk);
                chk("R7 idle after reject", O_IDLE);
                @(negedge clk);
                chk("R9 no late access", O_IDLE);
                return;
            end
            access("R6 buffer after reread", O_BUF, int'(v.dly));
        end else begin
            access("R2 buffer first", O_BUF, int'(v.dly));
        end
        access("R3 descriptor write", O_DWR, int'(v.dly));
        if (low) access("R4 resource read", O_RSRC, int'(v.dly));
        chk(v.cnt == v.mark ? "R10 equal count idle" : "R4 idle at end", O_IDLE);
        @(negedge clk);
        chk("R9 no late access", O_IDLE);
    endtask

    initial begin
        @(negedge clk);
        chk("R1 in reset", O_IDLE);
        pkt_req = 1'b1;
        @(negedge clk);
        chk("R1 reset ignores request", O_IDLE);
        pkt_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", O_IDLE);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R4: count sampled at buffer completion, later change ignored
        eol_prev = 1'b0; rbwc = 16'd4; eobc = 16'd10;
        start_pkt();
        access("R2 buffer first", O_BUF, 1);
        rbwc = 16'd500;
        access("R3 descriptor write", O_DWR, 1);
        access("R4 sampled low count", O_RSRC, 0);
        chk("R4 idle at end", O_IDLE);

        // R4: count high at buffer completion, drop afterwards -> no resource read
        rbwc = 16'd500;
        start_pkt();
        access("R2 buffer first", O_BUF, 0);
        rbwc = 16'd1;
        access("R3 descriptor write", O_DWR, 0);
        chk("R4 sampled high count", O_IDLE);

        // R9: request held high through a reject cycle produces nothing more
        eol_prev = 1'b1; link_data = 32'h0000_0001;
        start_pkt();
        access("R5 reread", O_RRD, 0);
        pkt_req = 1'b1;
        chk("R7 reject pulse", O_REJ);
        @(negedge clk);
        pkt_req = 1'b0;
        chk("R7 idle after reject", O_IDLE);

        // R1: reset in the middle of a frame
        eol_prev = 1'b0;
        start_pkt();
        chk("R2 buffer first", O_BUF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid frame", O_IDLE);
        @(negedge clk);
        chk("R1 stays idle", O_IDLE);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule